// File: doc/BRIEF.md
# Load Switch Enable Supervisor

This block is the digital sequencer that decides when the gate of a high-side power switch may be driven. It watches a digitized input-supply code, an enable pin, a current-limit comparator bit and a signed die-temperature code, and from them produces a gate-on request. It also drives an output discharge pulldown enable, a reverse-conduction block flag, and two status bits for a separate fault reporter. The analog gate driver, charge pump, slew shaping and current regulation sit outside and consume these outputs.

The supervisor holds one of four states: locked out on low supply, disabled, conducting, or thermally shut down. Supply lockout uses two thresholds, so that droop during an inrush does not make the switch chatter. Thermal shutdown can only trip while the switch conducts and is in current limit. The switch then stays off until the die has cooled a fixed amount below the trip point and restarts by itself. A lasting overload therefore makes it cycle on and off. Removing enable or supply clears the thermal latch.

Top module: `load_switch_supervisor`

## Requirements
- R1: After reset the gate is off, reverse block is asserted, overtemperature status is low, and the discharge output equals the discharge option bit.
- R2: The supply is qualified once the supply code is at or above UV_ON (default 200). It stays qualified until the code falls below UV_OFF (default 180). While the supply is not qualified the gate is off.
- R3: Lockout on low supply takes priority over enable, and enable takes priority over thermal state. With the supply qualified and enable inactive, the gate is off.
- R4: Parameter EN_ACTIVE_HIGH selects the enable polarity: 1 means a high pin enables, 0 means a low pin enables.
- R5: While conducting with the current-limit bit high, a temperature code at or above TEMP_TRIP (default 135) turns the gate off and raises overtemperature status. Without current limit, no temperature trips it.
- R6: After a thermal trip the gate stays off until the temperature code is at or below TEMP_RELEASE (default 115). It then restarts with no other stimulus, so a persistent overload cycles repeatedly.
- R7: Leaving thermal shutdown because enable or supply is removed clears the thermal latch. A later enable at a temperature between the thresholds turns the gate on.
- R8: Reverse block is asserted exactly when the gate is off.
- R9: With the discharge option set, the pulldown is on only in the supply-lockout and disabled states. With the option clear, it is never on.
- R10: Current-limit status equals the current-limit input while the gate is on and is low otherwise, in the same cycle. Overtemperature status is high exactly in thermal shutdown.
- R11: An enable change moves the gate at the first rising clock edge. Supply and temperature changes take effect at the second edge, because of one qualifying register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_code_i | input | VIN_W | Digitized input supply level |
| en_i | input | 1 | Enable pin, polarity set by EN_ACTIVE_HIGH |
| ilim_i | input | 1 | Current-limit comparator, high while limiting |
| temp_i | input | TEMP_W | Signed die temperature in degrees C |
| dsc_opt_i | input | 1 | Configuration: output discharge fitted |
| gate_on_o | output | 1 | Gate drive request |
| rev_block_o | output | 1 | Block reverse conduction |
| discharge_o | output | 1 | Output pulldown enable |
| otemp_o | output | 1 | Thermal shutdown active |
| ilim_o | output | 1 | In current limit while conducting |

## Verification
The key collision is a thermal trip and a removal of enable or supply landing on the same edge, or a removal while already in thermal shutdown. Priority must favor lockout or disable, and the thermal latch must not survive. The bench trips the switch, holds the temperature between the two thresholds, and then drops enable or the supply. It re-enables and expects the gate to come back on at once, with overtemperature status low and the pulldown following the option bit. A second collision, a trip armed while the temperature is swept through both thresholds in each direction, is judged against a hysteresis model in the bench.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [1:0] {
        SW_UVLO  = 2'd0,
        SW_DIS   = 2'd1,
        SW_ON    = 2'd2,
        SW_THERM = 2'd3
    } sw_state_e;

    typedef struct packed {
        sw_state_e st;
    } ctrl_reg_s;

    typedef struct packed {
        logic hot;
        logic cool;
    } temp_reg_s;

    typedef struct packed {
        logic ok;
    } uv_reg_s;

endpackage

// File: rtl/lss_uvlo.sv
module lss_uvlo
    import lss_pkg::*;
#(
    parameter int VIN_W  = 8,
    parameter int UV_ON  = 200,
    parameter int UV_OFF = 180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VIN_W-1:0] vin_code,
    output logic             supply_ok
);
    localparam logic [VIN_W-1:0] ON_CODE  = VIN_W'(UV_ON);
    localparam logic [VIN_W-1:0] OFF_CODE = VIN_W'(UV_OFF);

    uv_reg_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.ok) begin
            r_d.ok = (vin_code >= OFF_CODE);
        end else begin
            r_d.ok = (vin_code >= ON_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign supply_ok = r_q.ok;

    AST_UV_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && vin_code >= OFF_CODE) |=> supply_ok); // R2
    AST_UV_STAY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && vin_code < ON_CODE) |=> !supply_ok); // R2

endmodule

// File: rtl/lss_temp_cmp.sv
module lss_temp_cmp
    import lss_pkg::*;
#(
    parameter int TEMP_W       = 9,
    parameter int TEMP_TRIP    = 135,
    parameter int TEMP_RELEASE = 115
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              at_trip,
    output logic              below_release
);
    localparam logic signed [TEMP_W-1:0] TRIP_C = TEMP_W'(TEMP_TRIP);
    localparam logic signed [TEMP_W-1:0] REL_C  = TEMP_W'(TEMP_RELEASE);

    temp_reg_s r_d, r_q;
    logic signed [TEMP_W-1:0] t_s;

    assign t_s = $signed(temp_code);

    always_comb begin
        r_d      = r_q;
        r_d.hot  = (t_s >= TRIP_C);
        r_d.cool = (t_s <= REL_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign at_trip       = r_q.hot;
    assign below_release = r_q.cool;

    AST_TEMP_BANDS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_trip && below_release)); // R6

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
    import lss_pkg::*;
#(
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic en_pin,
    input  logic ilim,
    input  logic at_trip,
    input  logic below_release,
    input  logic dsc_opt,
    output logic gate_on,
    output logic rev_block,
    output logic discharge,
    output logic otemp,
    output logic ilim_status
);
    ctrl_reg_s r_d, r_q;
    logic      en_act;

    generate
        if (EN_ACTIVE_HIGH) begin : g_en_high
            assign en_act = en_pin;
        end else begin : g_en_low
            assign en_act = ~en_pin;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (!supply_ok) begin
            r_d.st = SW_UVLO;
        end else if (!en_act) begin
            r_d.st = SW_DIS;
        end else begin
            unique case (r_q.st)
                SW_UVLO, SW_DIS: r_d.st = SW_ON;
                SW_ON: begin
                    if (ilim && at_trip) begin
                        r_d.st = SW_THERM;
                    end
                end
                SW_THERM: begin
                    if (below_release) begin
                        r_d.st = SW_ON;
                    end
                end
                default: r_d.st = SW_UVLO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= SW_UVLO;
        end else begin
            r_q <= r_d;
        end
    end

    logic st_on, st_therm, st_off_pd;
    assign st_on     = (r_q.st == SW_ON);
    assign st_therm  = (r_q.st == SW_THERM);
    assign st_off_pd = (r_q.st == SW_UVLO) || (r_q.st == SW_DIS);

    assign gate_on     = st_on;
    assign rev_block   = ~st_on;
    assign discharge   = dsc_opt & st_off_pd;
    assign otemp       = st_therm;
    assign ilim_status = ilim & st_on;

    AST_LOCKOUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (r_q.st == SW_UVLO)); // R3
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !en_act) |=> (r_q.st == SW_DIS)); // R3
    AST_TRIP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && en_act && st_on && ilim && at_trip) |=> st_therm); // R5
    AST_TRIP_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_therm) |-> ($past(ilim) && $past(at_trip))); // R5
    AST_THERM_HOLDS_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_therm && supply_ok && en_act && !below_release) |=> st_therm); // R6
    AST_ONE_OFF_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_on, st_therm, discharge})); // R9

endmodule

// File: rtl/load_switch_supervisor.sv
module load_switch_supervisor
    import lss_pkg::*;
#(
    parameter int VIN_W          = 8,
    parameter int UV_ON          = 200,
    parameter int UV_OFF         = 180,
    parameter int TEMP_W         = 9,
    parameter int TEMP_TRIP      = 135,
    parameter int TEMP_RELEASE   = 115,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VIN_W-1:0]  vin_code_i,
    input  logic              en_i,
    input  logic              ilim_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              dsc_opt_i,
    output logic              gate_on_o,
    output logic              rev_block_o,
    output logic              discharge_o,
    output logic              otemp_o,
    output logic              ilim_o
);
    logic supply_ok;
    logic at_trip;
    logic below_release;

    lss_uvlo #(
        .VIN_W (VIN_W),
        .UV_ON (UV_ON),
        .UV_OFF(UV_OFF)
    ) u_uvlo (
        .clk      (clk),
        .rst_n    (rst_n),
        .vin_code (vin_code_i),
        .supply_ok(supply_ok)
    );

    lss_temp_cmp #(
        .TEMP_W      (TEMP_W),
        .TEMP_TRIP   (TEMP_TRIP),
        .TEMP_RELEASE(TEMP_RELEASE)
    ) u_temp (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp_code    (temp_i),
        .at_trip      (at_trip),
        .below_release(below_release)
    );

    lss_ctrl #(
        .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .en_pin       (en_i),
        .ilim         (ilim_i),
        .at_trip      (at_trip),
        .below_release(below_release),
        .dsc_opt      (dsc_opt_i),
        .gate_on      (gate_on_o),
        .rev_block    (rev_block_o),
        .discharge    (discharge_o),
        .otemp        (otemp_o),
        .ilim_status  (ilim_o)
    );

    AST_GATE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on_o) |-> $past(supply_ok)); // R2
    AST_REV_BLOCK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_on_o) |-> rev_block_o); // R8

endmodule

// File: tb/load_switch_supervisor_bench.sv
module load_switch_supervisor_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vin = '0;
    logic       en = 1'b0;
    logic       en_alt = 1'b1;
    logic       ilim = 1'b0;
    logic [8:0] temp = 9'd25;
    logic       dsc = 1'b1;

    logic gate, rblk, dchg, otmp, ilst;
    logic gate_a, rblk_a, dchg_a, otmp_a, ilst_a;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_switch_supervisor u_load_switch_supervisor (
        .clk(clk), .rst_n(rst_n), .vin_code_i(vin), .en_i(en), .ilim_i(ilim),
        .temp_i(temp), .dsc_opt_i(dsc), .gate_on_o(gate), .rev_block_o(rblk),
        .discharge_o(dchg), .otemp_o(otmp), .ilim_o(ilst)
    );

    load_switch_supervisor #(.EN_ACTIVE_HIGH(1'b0)) u_load_switch_supervisor_alt (
        .clk(clk), .rst_n(rst_n), .vin_code_i(vin), .en_i(en_alt), .ilim_i(ilim),
        .temp_i(temp), .dsc_opt_i(dsc), .gate_on_o(gate_a), .rev_block_o(rblk_a),
        .discharge_o(dchg_a), .otemp_o(otmp_a), .ilim_o(ilst_a)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ok_m;
        bit therm_m;
        int trips;
        tick(2);
        // R1 reset state
        chk("R1", "gate", gate, 1'b0);
        chk("R1", "rev_block", rblk, 1'b1);
        chk("R1", "otemp", otmp, 1'b0);
        chk("R1", "discharge", dchg, 1'b1);
        rst_n = 1'b1;
        tick(1);

        // R2 supply sweep up then down, hysteresis model in bench
        en = 1'b1; dsc = 1'b1; temp = 9'd25; ilim = 1'b0;
        ok_m = 1'b0;
        for (int v = 0; v < 256; v++) begin
            vin = 8'(v);
            ok_m = ok_m ? (v >= 180) : (v >= 200);
            tick(3);
            chk("R2", "gate up-sweep", gate, ok_m);
            chk("R8", "rev_block", rblk, !ok_m);
            chk("R9", "discharge", dchg, !ok_m);
        end
        for (int v = 255; v >= 0; v--) begin
            vin = 8'(v);
            ok_m = ok_m ? (v >= 180) : (v >= 200);
            tick(3);
            chk("R2", "gate down-sweep", gate, ok_m);
            chk("R8", "rev_block", rblk, !ok_m);
        end

        // R3 priority: low supply beats enable
        vin = 8'd100; en = 1'b1; tick(3);
        chk("R3", "gate in lockout", gate, 1'b0);
        chk("R9", "discharge in lockout", dchg, 1'b1);
        vin = 8'd255; en = 1'b0; tick(3);
        chk("R3", "gate disabled", gate, 1'b0);
        chk("R9", "discharge disabled", dchg, 1'b1);

        // R11 enable latency: one edge
        en = 1'b1; tick(1);
        chk("R11", "gate after one edge on enable", gate, 1'b1);
        chk("R9", "discharge while on", dchg, 1'b0);
        // R11 supply latency: two edges
        vin = 8'd100; tick(1);
        chk("R11", "gate after one edge on supply drop", gate, 1'b1);
        tick(1);
        chk("R11", "gate after two edges on supply drop", gate, 1'b0);
        vin = 8'd255; tick(3);

        // R4 active-low instance
        en_alt = 1'b0; tick(3);
        chk("R4", "active-low enable on", gate_a, 1'b1);
        en_alt = 1'b1; tick(3);
        chk("R4", "active-low enable off", gate_a, 1'b0);

        // R10 current-limit status same cycle
        ilim = 1'b1; #1;
        chk("R10", "ilim status while on", ilst, 1'b1);
        ilim = 1'b0; #1;
        chk("R10", "ilim status cleared", ilst, 1'b0);

        // R5 no trip without current limit, sweep to 255
        ilim = 1'b0;
        for (int t = 100; t < 256; t += 5) begin
            temp = 9'(t); tick(3);
            chk("R5", "no trip without limit", otmp, 1'b0);
            chk("R5", "gate kept", gate, 1'b1);
        end

        // R5/R6 sweep with limit through both thresholds
        temp = 9'd100; tick(3);
        ilim = 1'b1; therm_m = 1'b0;
        for (int t = 100; t <= 150; t++) begin
            temp = 9'(t);
            therm_m = therm_m ? !(t <= 115) : (t >= 135);
            tick(3);
            chk("R5", "otemp up-sweep", otmp, therm_m);
            chk("R5", "gate up-sweep", gate, !therm_m);
            chk("R9", "no discharge in thermal", dchg, 1'b0);
        end
        for (int t = 150; t >= 100; t--) begin
            temp = 9'(t);
            therm_m = therm_m ? !(t <= 115) : (t >= 135);
            tick(3);
            chk("R6", "otemp down-sweep", otmp, therm_m);
            chk("R6", "gate down-sweep", gate, !therm_m);
            chk("R10", "ilim status", ilst, !therm_m);
        end
        // negative temperature code stays cool
        temp = 9'h1F6; tick(3);
        chk("R6", "gate at -10C", gate, 1'b1);

        // R6 repeated cycling
        trips = 0;
        for (int k = 0; k < 5; k++) begin
            temp = 9'd140; tick(3);
            if (otmp) trips++;
            temp = 9'd110; tick(3);
            chk("R6", "restart after cooling", gate, 1'b1);
        end
        chk("R6", "five trips counted", trips == 5, 1'b1);

        // R7 disable during thermal shutdown clears latch
        temp = 9'd140; tick(3);
        chk("R7", "tripped", otmp, 1'b1);
        temp = 9'd125; tick(3);
        chk("R7", "held warm", gate, 1'b0);
        en = 1'b0; tick(3);
        chk("R7", "otemp cleared by disable", otmp, 1'b0);
        chk("R9", "discharge after disable", dchg, 1'b1);
        en = 1'b1; tick(3);
        chk("R7", "gate on after re-enable", gate, 1'b1);
        // R7 via supply lockout
        temp = 9'd140; tick(3);
        temp = 9'd125; tick(3);
        chk("R7", "tripped again", otmp, 1'b1);
        vin = 8'd100; tick(3);
        chk("R7", "otemp cleared by lockout", otmp, 1'b0);
        vin = 8'd255; tick(3);
        chk("R7", "gate on after supply return", gate, 1'b1);

        // R9 option cleared: never a pulldown
        dsc = 1'b0; ilim = 1'b0;
        en = 1'b0; tick(3);
        chk("R9", "no discharge disabled, option off", dchg, 1'b0);
        vin = 8'd0; tick(3);
        chk("R9", "no discharge lockout, option off", dchg, 1'b0);
        dsc = 1'b1; #1;
        chk("R9", "discharge follows option", dchg, 1'b1);

        finish_run();
    end
endmodule